// File: doc/BRIEF.md
# Queue Condition Status and Interrupt Unit

This block collects the live condition flags of 64 hardware queues and presents them through sixteen 32-bit words that software reads and writes. The queues fall into two groups that the block treats differently. Each of the 32 lower queues reports four condition bits: empty, nearly empty, nearly full and full. Each lower queue also keeps a sticky underflow flag and a sticky overflow flag, and has a field that chooses which of its four conditions drives its interrupt request. The 32 upper queues report only nearly-empty and full, one bit per queue, and their interrupt request always follows nearly-empty.

Each queue has one interrupt-status bit. A global mode bit chooses how these bits behave. In level mode each bit copies the queue's selected condition. In latched mode a bit is set on a rising edge of the selected condition and stays set until software writes a 1 to it. Each group has an enable word, and the group's interrupt line goes high when any enabled status bit in that group is set. Reads are combinational from the word address. A write takes effect at the next clock edge.

Top module: `qstat_irq_unit`

## Requirements
- R1: Word addresses 0 to 3 read the live lower conditions. Lower queue q appears in word q/8, bits [4*(q%8)+3 : 4*(q%8)]: bit 0 empty, bit 1 nearly empty, bit 2 nearly full, bit 3 full. These words are the `lo_cond` input taken 32 bits at a time.
- R2: A pulse on `lo_uf_evt[q]` sets bit 2*(q%16) of word 4+q/16. A pulse on `lo_of_evt[q]` sets bit 2*(q%16)+1 of the same word. The bit is set at the next clock edge.
- R3: Error bits are sticky. A write to word 4 or 5 clears the bits written as 0 and leaves the bits written as 1 unchanged, so a write can never set an error bit. If an event and a clearing write reach the same bit in the same cycle, the event wins.
- R4: Word 6 reads the nearly-empty flag of upper queue q at bit q-32. Word 7 reads the full flag of upper queue q at bit q-32.
- R5: Words 8 to 11 hold one 4-bit field per lower queue, laid out like R1. Bits [1:0] of the field select the interrupt condition: 0 empty, 1 nearly empty, 2 nearly full, 3 full. The interrupt condition of an upper queue is always nearly-empty.
- R6: Level mode is in effect when bit 3 of word 8 is 0. In level mode, each bit of word 14 (lower queues, bit q) and word 15 (upper queues, bit q-32) equals the queue's selected condition as sampled at the previous clock edge. Writes to words 14 and 15 have no effect in this mode.
- R7: Latched mode is in effect when bit 3 of word 8 is 1. In latched mode, an interrupt-status bit is set when its selected condition rises and stays set after the condition falls. Writing a 1 to the bit clears it. If a rise and a clear reach the same bit in the same cycle, the rise wins.
- R8: Word 12 enables the lower queues and word 13 enables the upper queues, one bit per queue. `irq_lo` and `irq_hi` are high exactly when the group's interrupt-status word ANDed with its enable word is nonzero.
- R9: Words 0 to 7 are read-only, and writes to them have no effect. Words 8 to 13 read back the value last written to them.
- R10: After reset, every stored word (error, select, enable and interrupt-status) is zero, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cond | input | 128 | Live conditions of the lower queues, 4 bits per queue |
| lo_uf_evt | input | 32 | Underflow event pulse, one bit per lower queue |
| lo_of_evt | input | 32 | Overflow event pulse, one bit per lower queue |
| hi_ne | input | 32 | Nearly-empty flag of each upper queue |
| hi_full | input | 32 | Full flag of each upper queue |
| reg_wen | input | 1 | Write strobe |
| reg_addr | input | 4 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_lo | output | 1 | Interrupt request of the lower group |
| irq_hi | output | 1 | Interrupt request of the upper group |

## Verification
The assertions check on every cycle that:
- an error bit is lost only through a write to an error word;
- an event pulse always leaves its error bit set;
- upper status bits copy nearly-empty in level mode and only accumulate in latched mode unless cleared;
- an interrupt line stays low while its enable word is zero.

Some behaviours can only be shown by the bench's directed scenarios. These are the bit packing of each word, the decoding of the source-select values, the precedence of set over clear, and the fact that writes to read-only and level-mode words are ignored. The bench shows them by reading the words back after known stimulus.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
    localparam int WORD_W        = 32;
    localparam int LO_Q          = 32;
    localparam int HI_Q          = 32;
    localparam int STAT_BITS     = 4;
    localparam int ERR_BITS      = 2;
    localparam int STAT_PER_WORD = WORD_W / STAT_BITS;
    localparam int ERR_PER_WORD  = WORD_W / ERR_BITS;
    localparam int N_STAT_W      = LO_Q / STAT_PER_WORD;
    localparam int N_ERR_W       = LO_Q / ERR_PER_WORD;
    localparam int N_SEL_W       = N_STAT_W;
    localparam int LO_COND_W     = LO_Q * STAT_BITS;
    localparam int ERR_W         = LO_Q * ERR_BITS;

    // word map
    localparam int A_STAT    = 0;
    localparam int A_ERR     = A_STAT + N_STAT_W;
    localparam int A_HNE     = A_ERR + N_ERR_W;
    localparam int A_HFULL   = A_HNE + 1;
    localparam int A_SEL     = A_HFULL + 1;
    localparam int A_EN_LO   = A_SEL + N_SEL_W;
    localparam int A_EN_HI   = A_EN_LO + 1;
    localparam int A_INT_LO  = A_EN_HI + 1;
    localparam int A_INT_HI  = A_INT_LO + 1;
    localparam int N_WORDS   = A_INT_HI + 1;
    localparam int ADDR_W    = $clog2(N_WORDS);

    localparam int LATCH_MODE_BIT = 3;

    typedef enum logic [1:0] {
        SRC_EMPTY = 2'd0,
        SRC_NEAR_EMPTY = 2'd1,
        SRC_NEAR_FULL = 2'd2,
        SRC_FULL = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } reg_wr_t;

    function automatic logic word_hit(input reg_wr_t w, input int a);
        return w.en && (int'(w.addr) == a);
    endfunction

    function automatic logic pick_cond(input logic [STAT_BITS-1:0] nib, input src_sel_e s);
        unique case (s)
            SRC_EMPTY:      return nib[0];
            SRC_NEAR_EMPTY: return nib[1];
            SRC_NEAR_FULL:  return nib[2];
            default:        return nib[3];
        endcase
    endfunction
endpackage

// File: rtl/qsi_cfg_regs.sv
module qsi_cfg_regs
    import qsi_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  reg_wr_t                    wr,
    output logic [N_SEL_W*WORD_W-1:0]  sel_flat,
    output logic [LO_Q-1:0]            en_lo,
    output logic [HI_Q-1:0]            en_hi,
    output logic                       latch_mode
);
    for (genvar w = 0; w < N_SEL_W; w++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst)
                sel_flat[w*WORD_W +: WORD_W] <= '0;
            else if (word_hit(wr, A_SEL + w))
                sel_flat[w*WORD_W +: WORD_W] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_lo <= '0;
            en_hi <= '0;
        end else begin
            if (word_hit(wr, A_EN_LO)) en_lo <= wr.data[LO_Q-1:0];
            if (word_hit(wr, A_EN_HI)) en_hi <= wr.data[HI_Q-1:0];
        end
    end

    assign latch_mode = sel_flat[LATCH_MODE_BIT];
endmodule

// File: rtl/qsi_err_latch.sv
module qsi_err_latch
    import qsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic [LO_Q-1:0]  uf_evt,
    input  logic [LO_Q-1:0]  of_evt,
    output logic [ERR_W-1:0] err
);
    logic [ERR_W-1:0] evt;

    for (genvar q = 0; q < LO_Q; q++) begin : g_pair
        assign evt[ERR_BITS*q]     = uf_evt[q];
        assign evt[ERR_BITS*q + 1] = of_evt[q];
    end

    for (genvar w = 0; w < N_ERR_W; w++) begin : g_word
        logic [WORD_W-1:0] keep;
        always_comb keep = word_hit(wr, A_ERR + w) ? wr.data : '1;
        always_ff @(posedge clk) begin
            if (rst)
                err[w*WORD_W +: WORD_W] <= '0;
            else
                err[w*WORD_W +: WORD_W] <= (err[w*WORD_W +: WORD_W] & keep)
                                         | evt[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/qsi_src_mux.sv
module qsi_src_mux
    import qsi_pkg::*;
(
    input  logic [LO_COND_W-1:0]       cond,
    input  logic [N_SEL_W*WORD_W-1:0]  sel_flat,
    output logic [LO_Q-1:0]            picked
);
    for (genvar q = 0; q < LO_Q; q++) begin : g_q
        src_sel_e s;
        assign s         = src_sel_e'(sel_flat[STAT_BITS*q +: 2]);
        assign picked[q] = pick_cond(cond[STAT_BITS*q +: STAT_BITS], s);
    end
endmodule

// File: rtl/qsi_int_gen.sv
module qsi_int_gen
    import qsi_pkg::*;
#(
    parameter int N        = 32,
    parameter int CLR_ADDR = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch_mode,
    input  logic [N-1:0]  cond,
    input  reg_wr_t       wr,
    output logic [N-1:0]  stat
);
    logic [N-1:0] cond_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr;

    always_comb begin
        rise = cond & ~cond_q;
        clr  = word_hit(wr, CLR_ADDR) ? wr.data[N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            stat   <= '0;
        end else begin
            cond_q <= cond;
            if (latch_mode)
                stat <= (stat & ~clr) | rise;
            else
                stat <= cond;
        end
    end
endmodule

// File: rtl/qstat_irq_unit.sv
module qstat_irq_unit
    import qsi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LO_COND_W-1:0]  lo_cond,
    input  logic [LO_Q-1:0]       lo_uf_evt,
    input  logic [LO_Q-1:0]       lo_of_evt,
    input  logic [HI_Q-1:0]       hi_ne,
    input  logic [HI_Q-1:0]       hi_full,
    input  logic                  reg_wen,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic                  irq_lo,
    output logic                  irq_hi
);
    reg_wr_t                     wr;
    logic [N_SEL_W*WORD_W-1:0]   sel_flat;
    logic [LO_Q-1:0]             en_lo;
    logic [HI_Q-1:0]             en_hi;
    logic                        latch_mode;
    logic [ERR_W-1:0]            err_flat;
    logic [LO_Q-1:0]             lo_pick;
    logic [LO_Q-1:0]             int_lo;
    logic [HI_Q-1:0]             int_hi;
    logic [WORD_W-1:0]           rd_words [N_WORDS];

    always_comb begin
        wr.en   = reg_wen;
        wr.addr = reg_addr;
        wr.data = reg_wdata;
    end

    qsi_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr(wr),
        .sel_flat(sel_flat), .en_lo(en_lo), .en_hi(en_hi),
        .latch_mode(latch_mode)
    );

    qsi_err_latch u_err (
        .clk(clk), .rst(rst), .wr(wr),
        .uf_evt(lo_uf_evt), .of_evt(lo_of_evt), .err(err_flat)
    );

    qsi_src_mux u_mux (
        .cond(lo_cond), .sel_flat(sel_flat), .picked(lo_pick)
    );

    qsi_int_gen #(.N(LO_Q), .CLR_ADDR(A_INT_LO)) u_int_lo (
        .clk(clk), .rst(rst), .latch_mode(latch_mode),
        .cond(lo_pick), .wr(wr), .stat(int_lo)
    );

    qsi_int_gen #(.N(HI_Q), .CLR_ADDR(A_INT_HI)) u_int_hi (
        .clk(clk), .rst(rst), .latch_mode(latch_mode),
        .cond(hi_ne), .wr(wr), .stat(int_hi)
    );

    always_comb begin
        for (int w = 0; w < N_STAT_W; w++)
            rd_words[A_STAT + w] = lo_cond[w*WORD_W +: WORD_W];
        for (int w = 0; w < N_ERR_W; w++)
            rd_words[A_ERR + w] = err_flat[w*WORD_W +: WORD_W];
        rd_words[A_HNE]   = WORD_W'(hi_ne);
        rd_words[A_HFULL] = WORD_W'(hi_full);
        for (int w = 0; w < N_SEL_W; w++)
            rd_words[A_SEL + w] = sel_flat[w*WORD_W +: WORD_W];
        rd_words[A_EN_LO]  = WORD_W'(en_lo);
        rd_words[A_EN_HI]  = WORD_W'(en_hi);
        rd_words[A_INT_LO] = WORD_W'(int_lo);
        rd_words[A_INT_HI] = WORD_W'(int_hi);
        reg_rdata = rd_words[reg_addr];
    end

    assign irq_lo = |(int_lo & en_lo);
    assign irq_hi = |(int_hi & en_hi);
endmodule

// File: rtl/qsi_checker.sv
module qsi_checker
    import qsi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [LO_Q-1:0]   lo_uf_evt,
    input logic [LO_Q-1:0]   lo_of_evt,
    input logic [ERR_W-1:0]  err_flat,
    input logic [HI_Q-1:0]   hi_ne,
    input logic [HI_Q-1:0]   int_hi,
    input logic [LO_Q-1:0]   en_lo,
    input logic [HI_Q-1:0]   en_hi,
    input logic              latch_mode,
    input logic              irq_lo,
    input logic              irq_hi
);
    logic err_wr;
    logic hi_clr_wr;
    logic [ERR_W-1:0] evt_flat;

    always_comb begin
        err_wr    = reg_wen && (int'(reg_addr) >= A_ERR) && (int'(reg_addr) < A_ERR + N_ERR_W);
        hi_clr_wr = reg_wen && (int'(reg_addr) == A_INT_HI);
        for (int q = 0; q < LO_Q; q++) begin
            evt_flat[2*q]   = lo_uf_evt[q];
            evt_flat[2*q+1] = lo_of_evt[q];
        end
    end

    // R3: no error bit drops without a write to an error word
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        !err_wr |=> ((err_flat & $past(err_flat)) == $past(err_flat)));

    // R2: an event always leaves its error bit set
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (rst)
        (|evt_flat) |=> ((err_flat & $past(evt_flat)) == $past(evt_flat)));

    // R6: level mode copies upper nearly-empty
    a_r6_level_follow: assert property (@(posedge clk) disable iff (rst)
        !latch_mode |=> (int_hi == $past(hi_ne)));

    // R7: latched mode only accumulates unless cleared
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && !hi_clr_wr) |=> ((int_hi & $past(int_hi)) == $past(int_hi)));

    // R8: no request without enable
    a_r8_lo_gated: assert property (@(posedge clk) disable iff (rst)
        (en_lo == '0) |-> !irq_lo);
    a_r8_hi_gated: assert property (@(posedge clk) disable iff (rst)
        (en_hi == '0) |-> !irq_hi);
endmodule

bind qstat_irq_unit qsi_checker u_chk (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .lo_uf_evt(lo_uf_evt), .lo_of_evt(lo_of_evt), .err_flat(err_flat),
    .hi_ne(hi_ne), .int_hi(int_hi), .en_lo(en_lo), .en_hi(en_hi),
    .latch_mode(latch_mode), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/qstat_irq_unit_tb.sv
`timescale 1ns/1ps
module qstat_irq_unit_tb;
    import qsi_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [LO_COND_W-1:0]  lo_cond = '0;
    logic [LO_Q-1:0]       lo_uf_evt = '0;
    logic [LO_Q-1:0]       lo_of_evt = '0;
    logic [HI_Q-1:0]       hi_ne = '0;
    logic [HI_Q-1:0]       hi_full = '0;
    logic                  reg_wen = 1'b0;
    logic [ADDR_W-1:0]     reg_addr = '0;
    logic [WORD_W-1:0]     reg_wdata = '0;
    logic [WORD_W-1:0]     reg_rdata;
    logic                  irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    qstat_irq_unit u_dut (
        .clk(clk), .rst(rst), .lo_cond(lo_cond), .lo_uf_evt(lo_uf_evt),
        .lo_of_evt(lo_of_evt), .hi_ne(hi_ne), .hi_full(hi_full),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        for (int a = A_ERR; a < N_WORDS; a++) rd_chk("R10 word", a, 32'h0);
        check("R10 irq", {30'd0, irq_hi, irq_lo}, 32'h0);
    endtask

    task automatic t_lo_status;
        lo_cond = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
        rd_chk("R1 w0", A_STAT + 0, 32'h76543210);
        rd_chk("R1 w1", A_STAT + 1, 32'hFEDCBA98);
        rd_chk("R1 w2", A_STAT + 2, 32'h89ABCDEF);
        rd_chk("R1 w3", A_STAT + 3, 32'h01234567);
        wr(A_STAT + 1, 32'h0);
        rd_chk("R9 ro stat", A_STAT + 1, 32'hFEDCBA98);
        lo_cond = '0;
    endtask

    task automatic t_hi_status;
        hi_ne = 32'h000000A5; hi_full = 32'h00000F00;
        rd_chk("R4 ne", A_HNE, 32'h000000A5);
        rd_chk("R4 full", A_HFULL, 32'h00000F00);
        wr(A_HFULL, 32'hFFFFFFFF);
        rd_chk("R9 ro full", A_HFULL, 32'h00000F00);
        hi_ne = '0; hi_full = '0;
    endtask

    task automatic t_errors;
        @(negedge clk); lo_uf_evt[17] = 1'b1; lo_of_evt[3] = 1'b1;
        @(negedge clk); lo_uf_evt = '0; lo_of_evt = '0;
        rd_chk("R2 uf q17", A_ERR + 1, 32'h00000004);
        rd_chk("R2 of q3", A_ERR + 0, 32'h00000080);
        rd_chk("R3 held", A_ERR + 0, 32'h00000080);
        wr(A_ERR + 0, 32'hFFFFFFFF);
        rd_chk("R3 write-1 keeps", A_ERR + 0, 32'h00000080);
        wr(A_ERR + 0, 32'h0);
        rd_chk("R3 write-0 clears", A_ERR + 0, 32'h0);
        rd_chk("R3 other word kept", A_ERR + 1, 32'h00000004);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = ADDR_W'(A_ERR + 1); reg_wdata = 32'h0; lo_of_evt[16] = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; lo_of_evt = '0;
        rd_chk("R3 event beats clear", A_ERR + 1, 32'h00000002);
        wr(A_ERR + 1, 32'h0);
    endtask

    task automatic t_select_level;
        logic [31:0] d;
        wr(A_SEL, 32'h00000030);
        rd_chk("R9 sel readback", A_SEL, 32'h00000030);
        lo_cond[5] = 1'b1;
        rd_chk("R5 q1 ne not selected", A_INT_LO, 32'h0);
        lo_cond[7] = 1'b1;
        rd_chk("R5 q1 full selected", A_INT_LO, 32'h00000002);
        wr(A_INT_LO, 32'hFFFFFFFF);
        rd_chk("R6 write ignored", A_INT_LO, 32'h00000002);
        hi_ne = 32'h00010000; hi_full = 32'h00000001;
        rd_chk("R5 hi fixed ne", A_INT_HI, 32'h00010000);
        lo_cond[7] = 1'b0;
        rd(A_INT_LO, d);
        check("R6 follows fall", d, 32'h0);
        lo_cond[7] = 1'b1;
        rd(A_INT_LO, d);
    endtask

    task automatic t_irq;
        wr(A_EN_LO, 32'h00000002);
        @(negedge clk); #1 check("R8 irq_lo on", {31'd0, irq_lo}, 32'h1);
        wr(A_EN_LO, 32'h00000001);
        @(negedge clk); #1 check("R8 irq_lo masked", {31'd0, irq_lo}, 32'h0);
        wr(A_EN_HI, 32'h00010000);
        rd_chk("R9 en readback", A_EN_HI, 32'h00010000);
        @(negedge clk); #1 check("R8 irq_hi on", {31'd0, irq_hi}, 32'h1);
        wr(A_EN_HI, 32'h0);
        @(negedge clk); #1 check("R8 irq_hi off", {31'd0, irq_hi}, 32'h0);
        wr(A_EN_LO, 32'h0);
        lo_cond = '0; hi_ne = '0; hi_full = '0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_latched;
        wr(A_SEL, 32'h00000008);
        rd_chk("R7 start clear", A_INT_LO, 32'h0);
        lo_cond[0] = 1'b1;
        rd_chk("R7 set on rise", A_INT_LO, 32'h00000001);
        lo_cond[0] = 1'b0;
        rd_chk("R7 held after fall", A_INT_LO, 32'h00000001);
        wr(A_INT_LO, 32'h00000001);
        rd_chk("R7 write-1 clears", A_INT_LO, 32'h0);
        hi_ne[3] = 1'b1;
        rd_chk("R7 hi set", A_INT_HI, 32'h00000008);
        hi_ne[3] = 1'b0;
        rd_chk("R7 hi held", A_INT_HI, 32'h00000008);
        wr(A_INT_HI, 32'h00000000);
        rd_chk("R7 write-0 keeps", A_INT_HI, 32'h00000008);
        wr(A_INT_HI, 32'h00000008);
        rd_chk("R7 hi cleared", A_INT_HI, 32'h0);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = ADDR_W'(A_INT_LO); reg_wdata = 32'h1; lo_cond[0] = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        rd_chk("R7 rise beats clear", A_INT_LO, 32'h00000001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lo_status();
        t_hi_status();
        t_errors();
        t_select_level();
        t_irq();
        t_latched();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule